// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic use an external 128K-word by 16-bit asynchronous static RAM that has separate low and high byte lanes. The host presents one access at a time on a valid/ready request port carrying a word address, a read/write flag, a two-bit lane mask and write data. Reads return their data on a response port that is pulsed valid for one cycle. The controller produces the memory's active-low chip select, write strobe, output enable and two lane enables. The shared data bus is modelled as separate outgoing data, incoming data and driver-enable signals.

Every timing window is a whole number of clock cycles. It is derived at elaboration from the clock period and the nanosecond limits of the memory's speed grade. The output enable stays high for the whole of each write. This means the shorter write-pulse minimum applies and the memory never drives the bus while the controller does.

Back-pressure rules: a request is taken on the rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle. The host keeps its request fields steady while `req_valid` is high and `req_ready` is low. Responses cannot be stalled.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, the chip select, write strobe, output enable and both lane enables are high, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` goes low on the next cycle and stays low until the access has finished. A request held while `req_ready` is low is not taken until `req_ready` returns.
- R3: A read holds the chip select and output enable low, with the write strobe high, for N_ACC cycles. The data is captured on the edge that ends that window, and `rsp_valid` is high for exactly the one cycle that follows.
- R4: Mask bit 0 selects the low lane (data bits 7:0, lane enable bit 0) and mask bit 1 selects the high lane (bits 15:8, lane enable bit 1). In a read response, the byte of a lane the mask does not select is zero.
- R5: A write holds the chip select and selected lane enables low with the write strobe high for N_SET cycles, then drives the write strobe low for N_PUL cycles. Output enable stays high throughout.
- R6: During a write the address is steady, and `mem_dq_oe` is high with the request's write data from the first setup cycle through one recovery cycle after the write strobe rises.
- R7: `mem_dq_oe` is never high while output enable is low. A write's drivers turn on only after at least N_TURN cycles in which output enable has been high.
- R8: The lane enables follow the mask in both reads and writes. A mask of 0 leaves both lanes disabled, no byte changes, and the access still completes.
- R9: Each window count equals the ceiling of its nanosecond limit divided by the clock period, and is at least 1. With the default 4 ns clock: N_ACC=3, N_TURN=2, N_SET=1, N_PUL=2, N_REC=1.
- R10: Whenever the chip select is high, the write strobe, output enable and both lane enables are high as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | 17 | Word address |
| req_we | input | 1 | 1 for write, 0 for read |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 low byte |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Controller data driver enable |

## Verification
The bench tests a write that follows a read immediately. A design that skips the turnaround would turn on its drivers while the memory still holds the bus. It tests lane-only reads and writes. A design that swaps the mask bits, or fails to zero the unselected byte, returns the bench's stand-in high-impedance byte or corrupts the neighbouring byte. It tests a write with an empty mask, where a wrong design would still store data. The bench counts how long each strobe stays low. A design with a short write pulse or access window, or one that lets a held request in while busy, differs from the reference on the first cycle it goes wrong.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_ACCESS,
    PH_RD_CAPTURE,
    PH_WR_SETUP,
    PH_WR_PULSE,
    PH_WR_RECOVER
  } phase_e;

  // Cycles needed to cover ns_val at a clock of clk_ns, never below one.
  function automatic int win_cycles(input int ns_val, input int clk_ns);
    int c;
    c = (ns_val + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_win_cnt.sv
module asram_win_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int N_ACC  = 3,
  parameter int N_TURN = 2,
  parameter int N_SET  = 1,
  parameter int N_PUL  = 2,
  parameter int N_REC  = 1,
  parameter int CNT_W  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   fire_we,
  output phase_e phase,
  output logic   cap_now
);

  phase_e           phase_q, phase_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             win_last;

  asram_win_cnt #(.CNT_W(CNT_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (win_last)
  );

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (fire) begin
          load = 1'b1;
          if (fire_we) begin
            phase_d  = PH_WR_SETUP;
            load_val = CNT_W'(N_SET - 1);
          end else begin
            phase_d  = PH_RD_ACCESS;
            load_val = CNT_W'(N_ACC - 1);
          end
        end
      end
      PH_RD_ACCESS: begin
        if (win_last) begin
          phase_d  = PH_RD_CAPTURE;
          load     = 1'b1;
          load_val = CNT_W'(N_TURN - 1);
        end
      end
      PH_RD_CAPTURE: begin
        if (win_last) phase_d = PH_IDLE;
      end
      PH_WR_SETUP: begin
        if (win_last) begin
          phase_d  = PH_WR_PULSE;
          load     = 1'b1;
          load_val = CNT_W'(N_PUL - 1);
        end
      end
      PH_WR_PULSE: begin
        if (win_last) begin
          phase_d  = PH_WR_RECOVER;
          load     = 1'b1;
          load_val = CNT_W'(N_REC - 1);
        end
      end
      PH_WR_RECOVER: begin
        if (win_last) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase   = phase_q;
  assign cap_now = (phase_q == PH_RD_ACCESS) && win_last;

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int LANES = 2
) (
  input  logic               active,
  input  logic [LANES-1:0]   mask,
  input  logic [8*LANES-1:0] rd_raw,
  output logic [LANES-1:0]   be_n,
  output logic [8*LANES-1:0] rd_kept
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n[g]          = ~(active & mask[g]);
    assign rd_kept[8*g +: 8] = mask[g] ? rd_raw[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 4,
  parameter int T_ADDR_NS  = 10,
  parameter int T_LANE_NS  = 6,
  parameter int T_OUTEN_NS = 5,
  parameter int T_RELEASE_NS = 5,
  parameter int T_ASU_NS   = 0,
  parameter int T_PULSE_NS = 8,
  parameter int T_CSW_NS   = 8,
  parameter int T_LSW_NS   = 8,
  parameter int T_DSU_NS   = 5,
  parameter int T_AHD_NS   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_we,
  input  logic [DATA_W/8-1:0]   req_mask,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int LANES  = DATA_W / 8;
  localparam int N_ACC  = win_cycles(max_of(max_of(T_ADDR_NS, T_LANE_NS), T_OUTEN_NS), CLK_NS);
  localparam int N_TURN = win_cycles(T_RELEASE_NS, CLK_NS);
  localparam int N_SET  = win_cycles(T_ASU_NS, CLK_NS);
  localparam int N_PUL  = win_cycles(max_of(max_of(T_PULSE_NS, T_CSW_NS),
                                            max_of(T_LSW_NS, T_DSU_NS)), CLK_NS);
  localparam int N_REC  = win_cycles(T_AHD_NS, CLK_NS);
  localparam int N_MAX  = max_of(max_of(max_of(N_ACC, N_TURN), max_of(N_SET, N_PUL)), N_REC);
  localparam int CNT_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  phase_e              phase;
  logic                cap_now;
  logic                fire;
  logic                strobe_on;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]    mask_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rd_kept;
  logic                rv_q;
  logic [DATA_W-1:0]   rd_q;

  assign req_ready = (phase == PH_IDLE);
  assign fire      = req_valid & req_ready;

  asram_fsm #(
    .N_ACC (N_ACC),
    .N_TURN(N_TURN),
    .N_SET (N_SET),
    .N_PUL (N_PUL),
    .N_REC (N_REC),
    .CNT_W (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .fire_we (req_we),
    .phase   (phase),
    .cap_now (cap_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
    end else if (fire) begin
      addr_q  <= req_addr;
      mask_q  <= req_mask;
      wdata_q <= req_wdata;
    end
  end

  assign strobe_on = (phase == PH_RD_ACCESS) || (phase == PH_WR_SETUP) ||
                     (phase == PH_WR_PULSE);

  asram_lanes #(.LANES(LANES)) u_lanes (
    .active  (strobe_on),
    .mask    (mask_q),
    .rd_raw  (mem_dq_in),
    .be_n    (mem_be_n),
    .rd_kept (rd_kept)
  );

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ~strobe_on;
  assign mem_oe_n   = ~(phase == PH_RD_ACCESS);
  assign mem_we_n   = ~(phase == PH_WR_PULSE);
  assign mem_dq_oe  = (phase == PH_WR_SETUP) || (phase == PH_WR_PULSE) ||
                      (phase == PH_WR_RECOVER);
  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= cap_now;
      if (cap_now) rd_q <= rd_kept;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int LANES  = 2,
  parameter int N_PUL  = 2,
  parameter int N_TURN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_ce_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_be_n,
  input logic             mem_dq_oe
);

  logic [7:0] we_low_cnt;
  logic [7:0] oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt  <= 8'd0;
      oe_high_cnt <= 8'hFF;
    end else begin
      we_low_cnt  <= !mem_we_n ? we_low_cnt + 8'd1 : 8'd0;
      if (!mem_oe_n)               oe_high_cnt <= 8'd0;
      else if (oe_high_cnt != 8'hFF) oe_high_cnt <= oe_high_cnt + 8'd1;
    end
  end

  // R10: deselected chip keeps all other strobes inactive
  a_r10_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && (&mem_be_n)));

  // R5: output enable held high while the write strobe is low
  a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R5 / R9: write strobe stays low for at least the pulse window
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= 8'(N_PUL)));

  // R7: never drive while the memory may drive
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7: turnaround gap before drivers switch on
  a_r7_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_cnt >= 8'(N_TURN)));

  // R3: response is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2: busy while a response is being returned
  a_r2_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .LANES (LANES),
  .N_PUL (N_PUL),
  .N_TURN(N_TURN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int CLK_PERIOD = 4;
  // R9: expected windows at 4 ns: ceil(10/4)=3, ceil(5/4)=2, 0->1, ceil(8/4)=2, 0->1
  localparam int NA = 3;
  localparam int NT = 2;
  localparam int NS = 1;
  localparam int NW = 2;
  localparam int NR = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_mask = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hBEEF;

  int nchk = 0;
  int nfail = 0;
  bit running = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_mask(req_mask), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] fill(input logic [16:0] a);
    return a[15:0] ^ 16'hC3A5;
  endfunction

  // golden contents (request level) and pin-level emulated contents
  logic [15:0] gmem [int];
  logic [15:0] pmem [int];

  function automatic logic [15:0] gword(input logic [16:0] a);
    return gmem.exists(int'(a)) ? gmem[int'(a)] : fill(a);
  endfunction
  function automatic logic [15:0] pword(input logic [16:0] a);
    return pmem.exists(int'(a)) ? pmem[int'(a)] : fill(a);
  endfunction

  // behavioural reference: phase 0 idle, 1 read access, 2 read turnaround,
  // 3 write setup, 4 write pulse, 5 write recover
  int          ph = 0;
  int          left = 0;
  logic        exp_rv = 1'b0;
  logic [15:0] exp_rd = '0;
  logic [15:0] pend_rd = '0;
  logic [16:0] m_addr = '0;
  logic [1:0]  m_mask = '0;
  logic [15:0] m_wd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; exp_rv = 1'b0;
    end else begin
      exp_rv = 1'b0;
      case (ph)
        0: if (req_valid) begin
             m_addr = req_addr; m_mask = req_mask; m_wd = req_wdata;
             if (req_we) begin
               logic [15:0] w;
               w = gword(req_addr);
               if (req_mask[0]) w[7:0]  = req_wdata[7:0];
               if (req_mask[1]) w[15:8] = req_wdata[15:8];
               gmem[int'(req_addr)] = w;
               ph = 3; left = NS;
             end else begin
               pend_rd = gword(req_addr) &
                         {{8{req_mask[1]}}, {8{req_mask[0]}}};
               ph = 1; left = NA;
             end
           end
        1: begin left--; if (left == 0) begin ph = 2; left = NT; exp_rv = 1'b1; exp_rd = pend_rd; end end
        2: begin left--; if (left == 0) ph = 0; end
        3: begin left--; if (left == 0) begin ph = 4; left = NW; end end
        4: begin left--; if (left == 0) begin ph = 5; left = NR; end end
        5: begin left--; if (left == 0) ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  // pin-level memory emulation; unselected read lanes show 8'hEE
  bit          pend_w = 1'b0;
  logic [16:0] w_addr;
  logic [1:0]  w_be;
  logic [15:0] w_data;
  int          we_len = 0;
  int          oe_gap = 99;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      pend_w = 1'b1; w_addr = mem_addr; w_be = mem_be_n; w_data = mem_dq_out;
      we_len++;
    end else if (pend_w && mem_we_n) begin
      logic [15:0] w;
      w = pword(w_addr);
      if (!w_be[0]) w[7:0]  = w_data[7:0];
      if (!w_be[1]) w[15:8] = w_data[15:8];
      pmem[int'(w_addr)] = w;
      pend_w = 1'b0;
      chk(we_len == NW, "R9 write strobe length", we_len, NW);
      we_len = 0;
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = {mem_be_n[1] ? 8'hEE : pword(mem_addr)[15:8],
                   mem_be_n[0] ? 8'hEE : pword(mem_addr)[7:0]};
    else
      mem_dq_in = 16'hBEEF;
  end

  // per-cycle comparison against the reference
  logic prev_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (running) begin
      bit act;
      act = (ph == 1) || (ph == 3) || (ph == 4);
      chk(req_ready == (ph == 0), "R2 ready", req_ready, ph == 0);
      chk(mem_ce_n == !act, "R10 chip select", mem_ce_n, !act);
      chk(mem_oe_n == !(ph == 1), "R3 output enable", mem_oe_n, !(ph == 1));
      chk(mem_we_n == !(ph == 4), "R5 write strobe", mem_we_n, !(ph == 4));
      chk(mem_be_n == ~({2{act}} & m_mask), "R8 lane enables", mem_be_n, ~({2{act}} & m_mask));
      chk(mem_dq_oe == (ph >= 3), "R6 driver enable", mem_dq_oe, ph >= 3);
      chk(rsp_valid == exp_rv, "R3 response strobe", rsp_valid, exp_rv);
      if (ph != 0) chk(mem_addr == m_addr, "R6 address", mem_addr, m_addr);
      if (ph >= 3) chk(mem_dq_out == m_wd, "R6 write data", mem_dq_out, m_wd);
      if (exp_rv) chk(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
      if (mem_dq_oe && !prev_dq_oe)
        chk(oe_gap >= NT, "R7 turnaround gap", oe_gap, NT);
      if (mem_dq_oe) chk(mem_oe_n, "R7 contention", mem_oe_n, 1);
    end
    oe_gap = !mem_oe_n ? 0 : oe_gap + 1;
    prev_dq_oe = mem_dq_oe;
  end

  task automatic op(input bit we, input logic [16:0] a, input logic [1:0] m,
                    input logic [15:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_mask = m; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) &&
        !mem_dq_oe && !rsp_valid, "R1 reset held", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe && !rsp_valid, "R1 after release",
        {req_ready, mem_ce_n, mem_dq_oe}, 6);
    running = 1'b1;
    // R2 back-pressure: each op after the first is presented while busy
    op(1'b1, 17'h00010, 2'b11, 16'h1234);
    op(1'b0, 17'h00010, 2'b11, 16'h0000);
    op(1'b1, 17'h00010, 2'b10, 16'h99FF);   // R8 high lane only
    op(1'b0, 17'h00010, 2'b11, 16'h0000);
    op(1'b1, 17'h00020, 2'b01, 16'hABCD);   // R8 low lane only
    op(1'b0, 17'h00020, 2'b10, 16'h0000);   // R4 high-lane read
    op(1'b0, 17'h00020, 2'b01, 16'h0000);   // R4 low-lane read
    op(1'b1, 17'h00030, 2'b00, 16'h5555);   // R8 empty mask
    op(1'b0, 17'h00030, 2'b11, 16'h0000);
    op(1'b0, 17'h00030, 2'b00, 16'h0000);   // R8 empty-mask read returns zero
    op(1'b1, 17'h1FFFF, 2'b11, 16'hFACE);   // top address
    op(1'b0, 17'h1FFFF, 2'b11, 16'h0000);
    op(1'b1, 17'h00000, 2'b11, 16'h0F0F);   // R7 read followed by write
    op(1'b1, 17'h00001, 2'b11, 16'h7E7E);   // write after write
    op(1'b0, 17'h00000, 2'b11, 16'h0000);
    op(1'b0, 17'h00001, 2'b11, 16'h0000);
    repeat (12) @(negedge clk);
    running = 1'b0;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule